// File: doc/BRIEF.md
# UART Receive-to-USB Forwarding Controller

This block decides when bytes gathered by a UART receiver are handed to a USB bulk IN endpoint. Received bytes go into a 128-entry FIFO. Each time the host issues an IN request, the block either streams out one packet of up to 64 bytes over a valid/ready byte interface, with a flag on the final byte, or answers with a zero-length packet.

In normal mode the block holds data back. It releases a packet only when a full 64 bytes are waiting, or when the line has been idle for three character times. One character time is ten bit periods, and the bit period is given as a clock-cycle count. In low-latency mode, every request releases whatever the FIFO holds. Software sets low-latency mode with bit 0 of an 8-bit control register. Hardware forces the mode on whenever the configured baud rate is below 46921 bps, and the baud input is compared on every cycle, so the rule is re-applied at once after a rate change. A FIFO overrun raises a sticky flag, and a read strobe clears it.

Top module: `uart_rx_forwarder`

## Requirements
- R1: After reset, `txValid`, `txLast`, `zlpStb` and `overrun` are 0 and the FIFO is empty.
- R2: Control register bit 0 is the software low-latency enable. Bits 7:1 always read as 0, and writes to them have no effect.
- R3: When `baudRate` < 46921, low-latency mode is active and `cfgRdData[0]` reads 1, whatever bit 0 was written to. At 46921 and above, both follow the written bit.
- R4: In normal mode, an IN request with fewer than 64 bytes buffered and no idle timeout is answered by a one-cycle `zlpStb` in the cycle after the request, and no data is sent.
- R5: In normal mode, an IN request with 64 or more bytes buffered starts a 64-byte packet, with `txValid` high in the cycle after the request.
- R6: In normal mode, once the line has been idle for at least 30 × `bitPeriod` cycles with data buffered, an IN request releases all buffered bytes, up to 64.
- R7: Every byte that arrives on `rxValid` restarts the idle timer.
- R8: In low-latency mode, an IN request releases all buffered bytes, up to 64. An empty FIFO gives a `zlpStb`.
- R9: A packet carries at most 64 bytes. `txLast` is high only together with the final byte of the packet, and any bytes beyond 64 stay buffered for later requests.
- R10: The FIFO holds 128 bytes. A byte that arrives while the FIFO is full is dropped and sets `overrun`, which stays set until `ovrRead` is pulsed.
- R11: While `txValid` is high and `txReady` is low, `txData` and `txLast` hold their values. IN requests that arrive during a packet are ignored.
- R12: Bytes leave in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByte | input | 8 | Received UART byte |
| rxValid | input | 1 | rxByte is valid this cycle |
| bitPeriod | input | 16 | Clock cycles per UART bit |
| baudRate | input | 24 | Configured baud rate in bps |
| cfgWr | input | 1 | Write strobe for the control register |
| cfgWrData | input | 8 | Control register write data |
| cfgRdData | output | 8 | Control register read value (bit 0 = effective low-latency) |
| ovrRead | input | 1 | Status read strobe; clears overrun |
| overrun | output | 1 | Sticky FIFO overrun flag |
| inReq | input | 1 | One-cycle bulk IN request strobe |
| txData | output | 8 | Outgoing byte |
| txValid | output | 1 | txData is valid |
| txReady | input | 1 | Consumer accepts txData |
| txLast | output | 1 | Final byte of the packet |
| zlpStb | output | 1 | Zero-length packet answer |

## Verification
The bench goes after the edges of the release rule. It requests with 63 or fewer bytes before the timeout and after it, at exactly 64 bytes, and with more than 64 bytes. A design that compares against the wrong threshold would answer with data where a zero-length packet is due, or the other way round. The bench also probes the baud threshold at 46920 and 46921, where an off-by-one compare would report the wrong mode. It refreshes the idle timer with a late byte, which catches a timer that measures from the first byte instead of the last. It overfills the FIFO past 128 bytes, where a design that wrote into a full FIFO would corrupt the byte order or skip the overrun flag. Random stalls on `txReady`, along with IN requests issued in the middle of a packet, expose data that changes during a stall and bursts that restart.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int CHAR_BITS  = 10;
  localparam int IDLE_CHARS = 3;

  typedef struct packed {
    logic pop;
    logic ovrClr;
  } fwdStrobes_t;
endpackage

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int BP_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [DATA_W-1:0]            rxByte,
  input  logic                         rxValid,
  input  logic [BP_W-1:0]              bitPeriod,
  input  fwdStrobes_t                  stb,
  output logic [DATA_W-1:0]            headData,
  output logic [$clog2(DEPTH+1)-1:0]   fillCount,
  output logic                         timedOut,
  output logic                         overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam int TW = BP_W + $clog2(CHAR_BITS*IDLE_CHARS+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [CW-1:0]     count;
  logic [TW-1:0]     idleCnt, limitVal;
  logic              doPush, doDrop;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush   = rxValid && (count != FULL);
  assign doDrop   = rxValid && (count == FULL);
  assign limitVal = TW'(bitPeriod) * TW'(CHAR_BITS*IDLE_CHARS);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      overrun <= 1'b0;
      idleCnt <= '0;
    end else begin
      if (doPush)  wrPtr <= nextPtr(wrPtr);
      if (stb.pop) rdPtr <= nextPtr(rdPtr);
      case ({doPush, stb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (doDrop)          overrun <= 1'b1;
      else if (stb.ovrClr) overrun <= 1'b0;
      if (rxValid)                 idleCnt <= '0;
      else if (idleCnt < limitVal) idleCnt <= idleCnt + 1'b1;
    end
  end

  assign headData  = mem[rdPtr];
  assign fillCount = count;
  assign timedOut  = (count != '0) && (idleCnt >= limitVal);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);
  assert_drop_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    doDrop |=> overrun);
  assert_sticky_ovr_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !stb.ovrClr |=> overrun);
  assert_timer_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && (bitPeriod != '0) && $stable(bitPeriod) |=> !timedOut);
endmodule

// File: rtl/fwd_control.sv
module fwd_control
  import fwd_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int PKT_MAX     = 64,
  parameter int BAUD_W      = 24,
  parameter int LOWLAT_BAUD = 46921
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inReq,
  input  logic [BAUD_W-1:0]          baudRate,
  input  logic                       cfgWr,
  input  logic [7:0]                 cfgWrData,
  output logic [7:0]                 cfgRdData,
  input  logic                       ovrRead,
  input  logic [$clog2(DEPTH+1)-1:0] fillCount,
  input  logic                       timedOut,
  output fwdStrobes_t                stb,
  output logic                       txValid,
  input  logic                       txReady,
  output logic                       txLast,
  output logic                       zlpStb
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int RW = $clog2(PKT_MAX+1);
  localparam logic [CW-1:0] PKT_C = CW'(PKT_MAX);

  logic          lowLatBit, forced, lowLatEff, release_, busy;
  logic [RW-1:0] remaining, takeCnt;

  assign forced    = baudRate < BAUD_W'(LOWLAT_BAUD);
  assign lowLatEff = lowLatBit || forced;
  assign cfgRdData = {7'b0, lowLatEff};
  assign release_  = lowLatEff ? (fillCount != '0)
                               : ((fillCount >= PKT_C) || timedOut);
  assign takeCnt   = (fillCount >= PKT_C) ? RW'(PKT_MAX) : RW'(fillCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowLatBit <= 1'b0;
      busy      <= 1'b0;
      remaining <= '0;
      zlpStb    <= 1'b0;
    end else begin
      zlpStb <= 1'b0;
      if (cfgWr) lowLatBit <= cfgWrData[0];
      if (busy) begin
        if (txReady) begin
          remaining <= remaining - 1'b1;
          if (remaining == RW'(1)) busy <= 1'b0;
        end
      end else if (inReq) begin
        if (release_) begin
          busy      <= 1'b1;
          remaining <= takeCnt;
        end else begin
          zlpStb <= 1'b1;
        end
      end
    end
  end

  assign txValid    = busy;
  assign txLast     = busy && (remaining == RW'(1));
  assign stb.pop    = busy && txReady;
  assign stb.ovrClr = ovrRead;

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[7:1] == 7'b0);
  assert_forced_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    (baudRate < BAUD_W'(LOWLAT_BAUD)) |-> cfgRdData[0]);
  assert_hold_back_R4: assert property (@(posedge clk) disable iff (!rstN)
    inReq && !busy && !lowLatEff && (fillCount < PKT_C) && !timedOut
      |=> zlpStb && !txValid);
  assert_full_pkt_R5: assert property (@(posedge clk) disable iff (!rstN)
    inReq && !busy && (fillCount >= PKT_C) |=> txValid);
  assert_lowlat_send_R8: assert property (@(posedge clk) disable iff (!rstN)
    inReq && !busy && lowLatEff && (fillCount != '0) |=> txValid);
  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);
  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txLast));
  assert_req_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy && inReq |=> !zlpStb);
endmodule

// File: rtl/uart_rx_forwarder.sv
module uart_rx_forwarder
  import fwd_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int PKT_MAX     = 64,
  parameter int BP_W        = 16,
  parameter int BAUD_W      = 24,
  parameter int LOWLAT_BAUD = 46921
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        rxByte,
  input  logic              rxValid,
  input  logic [BP_W-1:0]   bitPeriod,
  input  logic [BAUD_W-1:0] baudRate,
  input  logic              cfgWr,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              ovrRead,
  output logic              overrun,
  input  logic              inReq,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txLast,
  output logic              zlpStb
);
  localparam int CW = $clog2(DEPTH+1);

  fwdStrobes_t   stb;
  logic [CW-1:0] fillCount;
  logic          timedOut;

  fwd_datapath #(.DEPTH(DEPTH), .DATA_W(8), .BP_W(BP_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .bitPeriod(bitPeriod), .stb(stb), .headData(txData),
    .fillCount(fillCount), .timedOut(timedOut), .overrun(overrun)
  );

  fwd_control #(.DEPTH(DEPTH), .PKT_MAX(PKT_MAX), .BAUD_W(BAUD_W),
                .LOWLAT_BAUD(LOWLAT_BAUD)) u_ctl (
    .clk(clk), .rstN(rstN), .inReq(inReq), .baudRate(baudRate),
    .cfgWr(cfgWr), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .ovrRead(ovrRead), .fillCount(fillCount), .timedOut(timedOut),
    .stb(stb), .txValid(txValid), .txReady(txReady), .txLast(txLast),
    .zlpStb(zlpStb)
  );
endmodule

// File: tb/uart_rx_forwarder_bench.sv
module uart_rx_forwarder_bench;
  localparam int BP    = 4;
  localparam int LIMIT = BP * 30;

  logic clk = 0, rstN = 0;
  logic [7:0] rxByte = 0, cfgWrData = 0, cfgRdData, txData;
  logic rxValid = 0, cfgWr = 0, ovrRead = 0, overrun, inReq = 0;
  logic txValid, txReady = 0, txLast, zlpStb;
  logic [15:0] bitPeriod = 16'(BP);
  logic [23:0] baudRate = 24'd115200;

  int checks = 0, fails = 0;
  logic [7:0] model[$];
  bit idleLong = 0, expOvr = 0, curLL = 0;

  always #10 clk = ~clk;

  uart_rx_forwarder u_uart_rx_forwarder (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .bitPeriod(bitPeriod), .baudRate(baudRate), .cfgWr(cfgWr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .ovrRead(ovrRead),
    .overrun(overrun), .inReq(inReq), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txLast(txLast), .zlpStb(zlpStb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit llOf(input int baud, input bit en);
    return (baud < 46921) || en;
  endfunction

  function automatic int expRelease(input int size, input bit ll, input bit tOut);
    int n = (size > 64) ? 64 : size;
    if (ll) return n;
    return (size >= 64 || tOut) ? n : 0;
  endfunction

  task automatic setCfg(input int baud, input bit en);
    @(negedge clk);
    baudRate = 24'(baud);
    cfgWr = 1;
    cfgWrData = {7'($urandom), en};
    @(negedge clk);
    cfgWr = 0;
    curLL = llOf(baud, en);
    chk(cfgRdData == {7'b0, curLL}, "R2/R3", "cfg readback", cfgRdData, {7'b0, curLL});
  endtask

  task automatic pushBytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1;
      rxByte = 8'($urandom);
      if (model.size() < 128) model.push_back(rxByte);
      else expOvr = 1;
    end
    @(negedge clk);
    rxValid = 0;
    if (n > 0) idleLong = 0;
  endtask

  task automatic waitIdle(input bit longW);
    repeat (longW ? LIMIT + 10 : 5) @(negedge clk);
    if (longW) idleLong = 1;
  endtask

  task automatic checkOverrun();
    @(negedge clk);
    chk(overrun == expOvr, "R10", "overrun flag", overrun, expOvr);
    ovrRead = 1;
    @(negedge clk);
    ovrRead = 0;
    @(negedge clk);
    chk(overrun == 0, "R10", "overrun cleared", overrun, 0);
    expOvr = 0;
  endtask

  task automatic request(input int exp, input string req);
    int got = 0, guard = 0;
    bit prevStall = 0;
    logic [7:0] prevData = 0;
    @(negedge clk);
    inReq = 1;
    @(negedge clk);
    inReq = 0;
    if (exp == 0) begin
      chk(zlpStb == 1 && txValid == 0, req, "zero-length answer", {zlpStb, txValid}, 2);
      return;
    end
    chk(txValid == 1 && zlpStb == 0, req, "packet start", {txValid, zlpStb}, 2);
    while (got < exp && guard < 2000) begin
      guard++;
      if (prevStall)
        chk(txData == prevData, "R11", "data held in stall", txData, prevData);
      chk(txValid == 1, req, "valid during packet", txValid, 1);
      chk(txLast == (got == exp - 1), "R9", "last flag", txLast, got == exp - 1);
      txReady = ($urandom % 3) != 0;
      inReq = ($urandom % 8) == 0;
      if (txReady && txValid) begin
        chk(txData == model[0], "R12", "byte order", txData, model[0]);
        void'(model.pop_front());
        got++;
      end
      prevStall = !txReady;
      prevData = txData;
      @(negedge clk);
      inReq = 0;
    end
    txReady = 0;
    chk(txValid == 0 && zlpStb == 0, "R9/R11", "packet ended, no restart",
        {txValid, zlpStb}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(txValid == 0 && txLast == 0 && zlpStb == 0 && overrun == 0, "R1",
        "reset outputs", {txValid, txLast, zlpStb, overrun}, 0);
    chk(cfgRdData == 0, "R1", "reset cfg", cfgRdData, 0);

    setCfg(115200, 0);
    pushBytes(10); waitIdle(0);
    request(0, "R4");
    pushBytes(54); waitIdle(0);
    request(64, "R5");
    pushBytes(3); waitIdle(1);
    request(3, "R6");
    pushBytes(63); waitIdle(0);
    request(0, "R4");
    waitIdle(1);
    request(63, "R6");

    pushBytes(5); repeat (100) @(negedge clk);
    pushBytes(1); repeat (100) @(negedge clk);
    request(0, "R7");
    waitIdle(1);
    request(6, "R7");

    setCfg(115200, 1);
    request(0, "R8");
    pushBytes(3); waitIdle(0);
    request(3, "R8");

    setCfg(46920, 0);
    pushBytes(2); waitIdle(0);
    request(2, "R3");
    setCfg(46921, 0);
    pushBytes(2); waitIdle(0);
    request(0, "R3");
    waitIdle(1);
    request(2, "R3");

    setCfg(115200, 0);
    pushBytes(130);
    checkOverrun();
    request(64, "R10");
    waitIdle(1);
    request(64, "R9");
    request(0, "R4");

    for (int t = 0; t < 40; t++) begin
      int bauds[4] = '{9600, 46920, 46921, 115200};
      setCfg(bauds[$urandom % 4], 1'($urandom));
      pushBytes($urandom % 141);
      checkOverrun();
      waitIdle(1'($urandom));
      for (int k = 0; k < 3; k++) begin
        request(expRelease(model.size(), curLL, idleLong), "R5/R6/R8");
        waitIdle(1);
      end
      setCfg(9600, 0);
      while (model.size() > 0)
        request(expRelease(model.size(), 1, 0), "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    $urandom(1234);
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule